// File: doc/BRIEF.md
# Pad Function Router with Parallel GPIO

This block sits between a bank of chip pads and the peripherals and GPIO logic that share them. Software programs it over a simple register bus. Each pad has a configuration word. The word picks which output source drives the pad and sets the pad's buffer controls: input enable, output enable, open-drain, pull direction and slew.

Routing works in two independent directions. On the output side, a function code of zero gives the pad to the parallel GPIO data-out register, and the codes from one to the number of functions pick one of the peripheral output vectors. On the input side, each peripheral input has its own select register. A valid code in that register names one candidate pad, and the synchronised value of that pad is delivered to the input. Software must program both sides: the input is delivered only while the chosen pad is not in GPIO mode.

GPIO data is packed into 16-bit words. A bit position with no pad behind it reads as zero and ignores writes. Pad inputs pass through a two-flop synchroniser before they reach the data-in words or the peripheral inputs.

Top module: `pad_mux`

## Requirements
- R1: While reset is asserted and right after it is released, every configuration word, select register and data-out bit is zero. All pad output enables, pulls, slews and peripheral inputs are then 0, and every read returns 0.
- R2: A write takes effect at the clock edge at which `wr_en` is sampled high. Configuration word p is at address p and keeps bits [8:0]: func [2:0], in_en [3], out_en [4], open_drain [5], pull [7:6], slew [8]. Bits above 8 read back as 0.
- R3: With func 0, the pad's output value is data-out bit p, and its output enable equals out_en. Data-out word w is at address 0x60+w, and bit b of that word is pad 16*w+b.
- R4: With func f in 1..3, the pad value is `periph_do[(f-1)*28+p]` and its enable is `periph_oe[(f-1)*28+p]`, gated by out_en. With func 4..7, the pad is not driven: output enable 0 and value 0.
- R5: While out_en is 0, the pad's output enable is 0, whatever the function selected.
- R6: With open_drain set, `pad_o` is 0, and the output enable is asserted only while the selected value is 0.
- R7: A pull code of 01 asserts `pad_pd` and 10 asserts `pad_pu`. The codes 00 and 11 assert neither. `pad_slew` follows the slew bit.
- R8: A change on `pad_i` is seen in data-in word w (address 0x70+w) after exactly two clock edges.
- R9: While in_en is 0, the pad reads as 0 both in data-in and at any peripheral input that selects it.
- R10: Input select register i is at address 0x40+i and holds 3 bits. A code c from 1 to 6 chooses pad (7*i+5*c) mod 28. The synchronised value of that pad reaches `periph_di[i]` only while the pad's func is non-zero.
- R11: An input select code of 0 or 7 holds `periph_di[i]` at 0.
- R12: Data-out bits 12..15 of word 1 (no pad behind them) read 0 and ignore writes. Data-in bits with no pad read 0, and writes to data-in addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pad_i | input | 28 | Raw pad input levels |
| pad_o | output | 28 | Pad output values |
| pad_oe | output | 28 | Pad output enables |
| pad_pu | output | 28 | Pull-up request per pad |
| pad_pd | output | 28 | Pull-down request per pad |
| pad_slew | output | 28 | Slew control per pad |
| periph_do | input | 84 | Peripheral output values, one 28-bit slice per function |
| periph_oe | input | 84 | Peripheral output enables, same layout |
| periph_di | output | 4 | Routed peripheral inputs |

## Verification
The bench drives pads through every function code, including the codes above the implemented range. It runs with peripheral vectors that change every cycle, so GPIO, peripheral and undriven pads give visibly different outputs. Open-drain is tried with data-out toggling, which shows whether the enable releases on a high value. The input side is checked with random pad levels and held pad levels, which separate a two-edge synchroniser from a one-edge or three-edge one. Every select code is walked on every peripheral input, with the target pad alternately in GPIO and peripheral mode, and this shows both the candidate mapping and the agreement gate.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;

  localparam int ADDR_W = 8;
  localparam int WORD_W = 16;
  localparam int CFG_W  = 9;

  localparam logic [ADDR_W-1:0] SEL_BASE  = 8'h40;
  localparam logic [ADDR_W-1:0] DOUT_BASE = 8'h60;
  localparam logic [ADDR_W-1:0] DIN_BASE  = 8'h70;

  typedef struct packed {
    logic       slew;
    logic [1:0] pull;
    logic       od;
    logic       obe;
    logic       ibe;
    logic [2:0] func;
  } pad_cfg_t;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_UP   = 2'b10,
    PULL_RSVD = 2'b11
  } pull_e;

  // candidate pad reached by select code `code` of peripheral input `inp`
  function automatic int cand_pad(int inp, int code, int npads);
    return (7 * inp + 5 * code) % npads;
  endfunction

endpackage

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
  import pad_mux_pkg::*;
#(
  parameter int NUM_PADS  = 28,
  parameter int NUM_PIN   = 4,
  parameter int SEL_W     = 3,
  parameter int GPIO_BITS = 32
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [GPIO_BITS-1:0]       din_i,
  output logic [WORD_W-1:0]          rdata,
  output pad_cfg_t [NUM_PADS-1:0]    cfg_o,
  output logic [NUM_PIN*SEL_W-1:0]   sel_o,
  output logic [GPIO_BITS-1:0]       dout_o
);

  localparam int WORDS = GPIO_BITS / WORD_W;

  function automatic logic [GPIO_BITS-1:0] impl_mask();
    logic [GPIO_BITS-1:0] m;
    for (int b = 0; b < GPIO_BITS; b++) m[b] = (b < NUM_PADS);
    return m;
  endfunction

  localparam logic [GPIO_BITS-1:0] IMPL = impl_mask();

  pad_cfg_t [NUM_PADS-1:0]  cfg_q, cfg_d;
  logic [NUM_PIN*SEL_W-1:0] sel_q, sel_d;
  logic [GPIO_BITS-1:0]     dout_q, dout_d;

  // next-state: decode the address, wr_en is the clock enable below
  always_comb begin
    cfg_d  = cfg_q;
    sel_d  = sel_q;
    dout_d = dout_q;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (addr == ADDR_W'(p)) cfg_d[p] = pad_cfg_t'(wdata[CFG_W-1:0]);
    end
    for (int i = 0; i < NUM_PIN; i++) begin
      if (addr == SEL_BASE + ADDR_W'(i)) sel_d[i*SEL_W +: SEL_W] = wdata[SEL_W-1:0];
    end
    for (int w = 0; w < WORDS; w++) begin
      if (addr == DOUT_BASE + ADDR_W'(w))
        dout_d[w*WORD_W +: WORD_W] = wdata & IMPL[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      sel_q  <= '0;
      dout_q <= '0;
    end else if (wr_en) begin
      cfg_q  <= cfg_d;
      sel_q  <= sel_d;
      dout_q <= dout_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (addr == ADDR_W'(p)) rdata = WORD_W'(cfg_q[p]);
    end
    for (int i = 0; i < NUM_PIN; i++) begin
      if (addr == SEL_BASE + ADDR_W'(i)) rdata = WORD_W'(sel_q[i*SEL_W +: SEL_W]);
    end
    for (int w = 0; w < WORDS; w++) begin
      if (addr == DOUT_BASE + ADDR_W'(w)) rdata = dout_q[w*WORD_W +: WORD_W];
      if (addr == DIN_BASE + ADDR_W'(w))  rdata = din_i[w*WORD_W +: WORD_W];
    end
  end

  assign cfg_o  = cfg_q;
  assign sel_o  = sel_q;
  assign dout_o = dout_q;

endmodule

// File: rtl/pad_in_sync.sv
module pad_in_sync #(
  parameter int N = 28
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] stage1_q;
  logic [N-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/pad_out_route.sv
module pad_out_route
  import pad_mux_pkg::*;
#(
  parameter int NUM_PADS  = 28,
  parameter int NUM_FUNCS = 3
) (
  input  pad_cfg_t [NUM_PADS-1:0]       cfg,
  input  logic [NUM_PADS-1:0]           gpio_do,
  input  logic [NUM_FUNCS*NUM_PADS-1:0] periph_do,
  input  logic [NUM_FUNCS*NUM_PADS-1:0] periph_oe,
  output logic [NUM_PADS-1:0]           pad_o,
  output logic [NUM_PADS-1:0]           pad_oe,
  output logic [NUM_PADS-1:0]           pad_pu,
  output logic [NUM_PADS-1:0]           pad_pd,
  output logic [NUM_PADS-1:0]           pad_slew
);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic sel_val;
    logic sel_en;

    always_comb begin
      sel_val = 1'b0;
      sel_en  = 1'b0;
      if (cfg[p].func == 3'd0) begin
        sel_val = gpio_do[p];
        sel_en  = 1'b1;
      end
      for (int f = 1; f <= NUM_FUNCS; f++) begin
        if (cfg[p].func == 3'(f)) begin
          sel_val = periph_do[(f-1)*NUM_PADS + p];
          sel_en  = periph_oe[(f-1)*NUM_PADS + p];
        end
      end
    end

    always_comb begin
      pad_o[p]    = sel_val & ~cfg[p].od;
      pad_oe[p]   = cfg[p].obe & sel_en & (~cfg[p].od | ~sel_val);
      pad_pu[p]   = (pull_e'(cfg[p].pull) == PULL_UP);
      pad_pd[p]   = (pull_e'(cfg[p].pull) == PULL_DOWN);
      pad_slew[p] = cfg[p].slew;
    end
  end

endmodule

// File: rtl/periph_in_route.sv
module periph_in_route
  import pad_mux_pkg::*;
#(
  parameter int NUM_PADS = 28,
  parameter int NUM_PIN  = 4,
  parameter int NUM_CAND = 6,
  parameter int SEL_W    = 3
) (
  input  pad_cfg_t [NUM_PADS-1:0]     cfg,
  input  logic [NUM_PADS-1:0]         in_gated,
  input  logic [NUM_PIN*SEL_W-1:0]    sel,
  output logic [NUM_PIN-1:0]          periph_di
);

  for (genvar i = 0; i < NUM_PIN; i++) begin : g_inp
    always_comb begin
      periph_di[i] = 1'b0;
      for (int c = 1; c <= NUM_CAND; c++) begin
        if (sel[i*SEL_W +: SEL_W] == SEL_W'(c)) begin
          periph_di[i] = in_gated[cand_pad(i, c, NUM_PADS)]
                       & (cfg[cand_pad(i, c, NUM_PADS)].func != 3'd0);
        end
      end
    end
  end

endmodule

// File: rtl/pad_mux.sv
module pad_mux
  import pad_mux_pkg::*;
#(
  parameter int NUM_PADS  = 28,
  parameter int NUM_FUNCS = 3,
  parameter int NUM_PIN   = 4,
  parameter int NUM_CAND  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [WORD_W-1:0]             wdata,
  output logic [WORD_W-1:0]             rdata,
  input  logic [NUM_PADS-1:0]           pad_i,
  output logic [NUM_PADS-1:0]           pad_o,
  output logic [NUM_PADS-1:0]           pad_oe,
  output logic [NUM_PADS-1:0]           pad_pu,
  output logic [NUM_PADS-1:0]           pad_pd,
  output logic [NUM_PADS-1:0]           pad_slew,
  input  logic [NUM_FUNCS*NUM_PADS-1:0] periph_do,
  input  logic [NUM_FUNCS*NUM_PADS-1:0] periph_oe,
  output logic [NUM_PIN-1:0]            periph_di
);

  localparam int GPIO_WORDS = (NUM_PADS + WORD_W - 1) / WORD_W;
  localparam int GPIO_BITS  = GPIO_WORDS * WORD_W;
  localparam int SEL_W      = $clog2(NUM_CAND + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  pad_cfg_t [NUM_PADS-1:0]  cfg;
  logic [NUM_PIN*SEL_W-1:0] sel_flat;
  logic [GPIO_BITS-1:0]     dout;
  logic [NUM_PADS-1:0]      pad_sync;
  logic [NUM_PADS-1:0]      in_gated;
  logic [NUM_PADS-1:0]      od_vec;
  logic [NUM_PADS-1:0]      obe_vec;
  logic [GPIO_BITS-1:0]     din_vec;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_gate
    assign in_gated[p] = pad_sync[p] & cfg[p].ibe;
    assign od_vec[p]   = cfg[p].od;
    assign obe_vec[p]  = cfg[p].obe;
  end

  assign din_vec = GPIO_BITS'(in_gated);

  pad_cfg_regs #(
    .NUM_PADS (NUM_PADS),
    .NUM_PIN  (NUM_PIN),
    .SEL_W    (SEL_W),
    .GPIO_BITS(GPIO_BITS)
  ) u_regs (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .din_i (din_vec),
    .rdata (rdata),
    .cfg_o (cfg),
    .sel_o (sel_flat),
    .dout_o(dout)
  );

  pad_in_sync #(.N(NUM_PADS)) u_sync (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .d     (pad_i),
    .q     (pad_sync)
  );

  pad_out_route #(
    .NUM_PADS (NUM_PADS),
    .NUM_FUNCS(NUM_FUNCS)
  ) u_out (
    .cfg      (cfg),
    .gpio_do  (dout[NUM_PADS-1:0]),
    .periph_do(periph_do),
    .periph_oe(periph_oe),
    .pad_o    (pad_o),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .pad_slew (pad_slew)
  );

  periph_in_route #(
    .NUM_PADS(NUM_PADS),
    .NUM_PIN (NUM_PIN),
    .NUM_CAND(NUM_CAND),
    .SEL_W   (SEL_W)
  ) u_in (
    .cfg      (cfg),
    .in_gated (in_gated),
    .sel      (sel_flat),
    .periph_di(periph_di)
  );

endmodule

// File: rtl/pad_mux_chk.sv
module pad_mux_chk #(
  parameter int NUM_PADS = 28,
  parameter int NUM_PIN  = 4,
  parameter int NUM_CAND = 6,
  parameter int SEL_W    = 3
) (
  input logic                       clk,
  input logic                       rst_ni,
  input logic [NUM_PADS-1:0]        pad_i,
  input logic [NUM_PADS-1:0]        sync_q,
  input logic [NUM_PADS-1:0]        pad_o,
  input logic [NUM_PADS-1:0]        pad_oe,
  input logic [NUM_PADS-1:0]        pad_pu,
  input logic [NUM_PADS-1:0]        pad_pd,
  input logic [NUM_PADS-1:0]        od_vec,
  input logic [NUM_PADS-1:0]        obe_vec,
  input logic [NUM_PIN-1:0]         periph_di,
  input logic [NUM_PIN*SEL_W-1:0]   sel_flat
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sync_q == $past(pad_i, 2)));  // R8

  AST_NO_OE_WITHOUT_OBE: assert property (@(posedge clk) disable iff (!rst_ni)
    (pad_oe & ~obe_vec) == '0);  // R5

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    (pad_o & od_vec) == '0);  // R6

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    (pad_pu & pad_pd) == '0);  // R7

  for (genvar i = 0; i < NUM_PIN; i++) begin : g_sel
    AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
      ((sel_flat[i*SEL_W +: SEL_W] == '0) ||
       (int'(sel_flat[i*SEL_W +: SEL_W]) > NUM_CAND)) |-> !periph_di[i]);  // R11
  end

endmodule

bind pad_mux pad_mux_chk #(
  .NUM_PADS(NUM_PADS),
  .NUM_PIN (NUM_PIN),
  .NUM_CAND(NUM_CAND),
  .SEL_W   (SEL_W)
) u_chk (
  .clk      (clk),
  .rst_ni   (rst_int_n),
  .pad_i    (pad_i),
  .sync_q   (pad_sync),
  .pad_o    (pad_o),
  .pad_oe   (pad_oe),
  .pad_pu   (pad_pu),
  .pad_pd   (pad_pd),
  .od_vec   (od_vec),
  .obe_vec  (obe_vec),
  .periph_di(periph_di),
  .sel_flat (sel_flat)
);

// File: tb/pad_mux_test.sv
module pad_mux_test;

  localparam int NP = 28;
  localparam int NF = 3;
  localparam int NI = 4;
  localparam int NC = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           wr_en;
  logic [7:0]     addr;
  logic [15:0]    wdata;
  logic [15:0]    rdata;
  logic [NP-1:0]  pad_i, pad_o, pad_oe, pad_pu, pad_pd, pad_slew;
  logic [NF*NP-1:0] periph_do, periph_oe;
  logic [NI-1:0]  periph_di;

  pad_mux uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_slew(pad_slew),
    .periph_do(periph_do), .periph_oe(periph_oe), .periph_di(periph_di)
  );

  int checks = 0;
  int errors = 0;
  bit rand_pad = 0;
  bit done = 0;

  // behavioural reference state
  logic [8:0]  mcfg [NP];
  logic [2:0]  msel [NI];
  logic [31:0] mdout = '0;
  logic [31:0] ms1 = '0;
  logic [31:0] ms2 = '0;
  bit mr1 = 0;
  bit mr2 = 0;

  initial begin
    for (int p = 0; p < NP; p++) mcfg[p] = '0;
    for (int i = 0; i < NI; i++) msel[i] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) mcfg[p] = '0;
      for (int i = 0; i < NI; i++) msel[i] = '0;
      mdout = '0; ms1 = '0; ms2 = '0; mr1 = 0; mr2 = 0;
    end else begin
      if (mr2) begin
        if (wr_en) begin
          if (addr < NP) mcfg[addr] = wdata[8:0];
          else if (addr >= 8'h40 && addr < 8'h40 + NI) msel[addr - 8'h40] = wdata[2:0];
          else if (addr == 8'h60) mdout[15:0] = wdata;
          else if (addr == 8'h61) mdout[31:16] = {4'h0, wdata[11:0]};
        end
        ms2 = ms1;
        ms1 = {4'h0, pad_i};
      end
      mr2 = mr1;
      mr1 = 1;
    end
  end

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0]   ing;
    logic [NP-1:0] e_o, e_oe, e_pu, e_pd, e_sl;
    logic [NI-1:0] e_di;
    logic [15:0]   e_rd;
    ing = '0;
    for (int p = 0; p < NP; p++) begin
      logic [2:0] f;
      logic v, en, od;
      ing[p] = ms2[p] & mcfg[p][3];
      f = mcfg[p][2:0];
      od = mcfg[p][5];
      if (f == 0) begin v = mdout[p]; en = 1; end
      else if (f <= NF) begin v = periph_do[(f-1)*NP + p]; en = periph_oe[(f-1)*NP + p]; end
      else begin v = 0; en = 0; end
      e_o[p]  = v & !od;
      e_oe[p] = mcfg[p][4] & en & (!od | !v);
      e_pu[p] = (mcfg[p][7:6] == 2'b10);
      e_pd[p] = (mcfg[p][7:6] == 2'b01);
      e_sl[p] = mcfg[p][8];
    end
    for (int i = 0; i < NI; i++) begin
      int c;
      c = msel[i];
      e_di[i] = 0;
      if (c >= 1 && c <= NC) begin
        int q;
        q = (7 * i + 5 * c) % NP;
        e_di[i] = ing[q] & (mcfg[q][2:0] != 0);
      end
    end
    e_rd = '0;
    if (addr < NP) e_rd = {7'h0, mcfg[addr]};
    else if (addr >= 8'h40 && addr < 8'h40 + NI) e_rd = {13'h0, msel[addr - 8'h40]};
    else if (addr == 8'h60) e_rd = mdout[15:0];
    else if (addr == 8'h61) e_rd = mdout[31:16];
    else if (addr == 8'h70) e_rd = ing[15:0];
    else if (addr == 8'h71) e_rd = ing[31:16];
    chk(tag, "pad_o", 128'(pad_o), 128'(e_o));
    chk(tag, "pad_oe", 128'(pad_oe), 128'(e_oe));
    chk(tag, "pad_pu", 128'(pad_pu), 128'(e_pu));
    chk(tag, "pad_pd", 128'(pad_pd), 128'(e_pd));
    chk(tag, "pad_slew", 128'(pad_slew), 128'(e_sl));
    chk(tag, "periph_di", 128'(periph_di), 128'(e_di));
    chk(tag, "rdata", 128'(rdata), 128'(e_rd));
  endtask

  task automatic step(string tag);
    if (rand_pad) pad_i = NP'($urandom);
    periph_do = (NF*NP)'({$urandom, $urandom, $urandom});
    periph_oe = (NF*NP)'({$urandom, $urandom, $urandom});
    @(negedge clk);
    #2;
    check_all(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, string tag);
    wr_en = 1; addr = a; wdata = d;
    step(tag);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    addr = a;
    step(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; addr = 0; wdata = 0; pad_i = '0;
    periph_do = '0; periph_oe = '0;
    repeat (3) step("R1");
    rst_n = 1;
    repeat (3) step("R1");
    rd(8'h00, "R1"); rd(8'h1B, "R1"); rd(8'h40, "R1"); rd(8'h60, "R1");
    rd(8'h61, "R1"); rd(8'h70, "R1");

    // R2: write, read back, upper bits dropped
    wr(8'h05, 16'hFFFF, "R2"); rd(8'h05, "R2");
    wr(8'h06, 16'h0153, "R2"); rd(8'h06, "R2");

    // R3: all pads GPIO, out_en + in_en
    for (int p = 0; p < NP; p++) wr(8'(p), 16'h0018, "R3");
    wr(8'h60, 16'hA5A5, "R3"); rd(8'h60, "R3");
    wr(8'h61, 16'h0A3C, "R3"); rd(8'h61, "R3");
    wr(8'h60, 16'h5A5A, "R3"); repeat (3) step("R3");

    // R12: unimplemented positions and read-only data-in
    wr(8'h61, 16'hFFFF, "R12"); rd(8'h61, "R12");
    wr(8'h70, 16'hFFFF, "R12"); rd(8'h70, "R12");
    rand_pad = 1;
    rd(8'h71, "R12"); rd(8'h71, "R12"); rd(8'h62, "R12"); rd(8'h3F, "R12");
    rand_pad = 0;

    // R4: every function code, including undriven ones
    for (int p = 0; p < NP; p++) wr(8'(p), 16'h0018 | 16'(p % 8), "R4");
    repeat (10) step("R4");

    // R5: output buffer disabled
    for (int p = 0; p < 8; p++) wr(8'(p), 16'h0008 | 16'(p % 4), "R5");
    repeat (6) step("R5");

    // R6: open-drain with toggling data
    for (int p = 8; p < 16; p++) wr(8'(p), 16'h0038 | 16'(p % 2), "R6");
    wr(8'h60, 16'hFF00, "R6"); repeat (4) step("R6");
    wr(8'h60, 16'h5500, "R6"); repeat (4) step("R6");

    // R7: pull and slew decode
    for (int p = 0; p < NP; p++)
      wr(8'(p), 16'h0010 | 16'((p % 4) << 6) | 16'(((p / 4) % 2) << 8), "R7");
    repeat (3) step("R7");

    // R8: synchroniser latency
    for (int p = 0; p < NP; p++) wr(8'(p), 16'h0008, "R8");
    addr = 8'h70;
    pad_i = '1; repeat (3) step("R8");
    pad_i = '0; repeat (3) step("R8");
    rand_pad = 1;
    repeat (10) step("R8");
    addr = 8'h71;
    repeat (10) step("R8");

    // R9: input buffer disabled on odd pads
    for (int p = 1; p < NP; p += 2) wr(8'(p), 16'h0001, "R9");
    addr = 8'h70; repeat (6) step("R9");
    addr = 8'h71; repeat (6) step("R9");

    // R10: every code on every input, pads alternating GPIO / peripheral
    for (int p = 0; p < NP; p++) wr(8'(p), 16'h0008 | 16'((p % 2 == 0) ? 1 : 0), "R10");
    for (int i = 0; i < NI; i++) begin
      for (int c = 1; c <= NC; c++) begin
        wr(8'(8'h40 + i), 16'(c), "R10");
        repeat (4) step("R10");
      end
    end
    for (int p = 0; p < NP; p++) wr(8'(p), 16'h000A, "R10");
    for (int i = 0; i < NI; i++) begin
      wr(8'(8'h40 + i), 16'(1 + i), "R10");
      repeat (4) step("R10");
    end

    // R11: invalid select codes
    for (int i = 0; i < NI; i++) wr(8'(8'h40 + i), 16'h0007, "R11");
    rd(8'h41, "R11");
    repeat (6) step("R11");
    for (int i = 0; i < NI; i++) wr(8'(8'h40 + i), 16'h0000, "R11");
    repeat (6) step("R11");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule